// File: doc/BRIEF.md
# Asynchronous Static RAM Byte-Lane Controller

This block lets synchronous logic use a 16-bit wide, one-million-word asynchronous static RAM. A client offers one request at a time through a ready/valid handshake. Each request carries a word address, a read/write flag, write data and a two-bit lane mask. For a read, the controller returns the data word together with a one-cycle valid pulse. The controller turns each request into a timed sequence of memory strobes: a pair of chip selects with opposite polarity, an active-low output enable, an active-low write enable, and one active-low enable per byte lane.

All memory timing is given as parameters in nanoseconds and converted to whole clock cycles, rounding up. This keeps the access time, the output-enable-to-data time, the output float time and the write pulse width satisfied at any clock period the parameters describe. The controller also decides who drives the shared data bus. It has a separate output-enable for each lane, and it leaves the memory enough time to release the bus after a read before it drives write data.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it, the outputs are idle: `mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_be_n`=2'b11, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: `mem_ce1_n` is always the inverse of `mem_ce2`. The chip is selected (`mem_ce1_n` low) only during the strobe phases of an access and never while the controller is idle.
- R3: A read holds `mem_oe_n` low and `mem_we_n` high for exactly RD_CYC cycles, where RD_CYC is the larger of the rounded access time and the rounded output-enable time. During that window `mem_be_n` equals the inverted mask: mask bit 0 is lane 0, data bits 7:0, and mask bit 1 is lane 1, data bits 15:8.
- R4: Read data is captured on the clock edge that ends the RD_CYC window. In the cycle that follows, `rsp_valid` is high for exactly one cycle with `rsp_rdata` and `mem_oe_n` back high. A write produces no `rsp_valid`.
- R5: A lane whose mask bit is 0 returns zero in `rsp_rdata`, whatever the memory presents on it.
- R6: The controller never drives any lane while `mem_oe_n` is low. After `mem_oe_n` rises, it drives no lane for at least HZ_CYC cycles (the rounded float time).
- R7: A write has three phases. First, one setup cycle with the chip selected, address, lane enables and data applied, and `mem_we_n` high. Then `mem_we_n` is low for exactly WE_CYC cycles with `mem_oe_n` high. Last, one hold cycle with `mem_we_n` high and the chip still selected.
- R8: Address, lane enables and write data do not change while `mem_we_n` is low, nor in the hold cycle that follows it.
- R9: During a write, the controller drives exactly the lanes whose mask bit is 1 (`mem_dq_oe` equals the mask) and leaves the others released.
- R10: A request is accepted in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only when the controller is idle. After an accepted read, `req_ready` stays low for RD_CYC+HZ_CYC cycles. After an accepted write, it stays low for WE_CYC+2 cycles. A request offered while the controller is busy and withdrawn before `req_ready` returns causes no memory access.
- R11: Each cycle count is ceil(time_ns / CLK_PERIOD_NS), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, unmasked lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | 2 | Active-low lane enables |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 2 | Per-lane drive enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
Every cycle, the assertions check the strobe relationships. The two selects always stay complementary. Output enable and write enable are never low together. The bus is never driven under a low output enable or sooner than the float time after it rises. Address, lane enables and data hold steady across the write pulse and its hold cycle, the read strobe lasts one cycle, and the controller is quiet whenever it reports ready. Only the bench scenarios can show the rest: the exact lengths of the read and write windows, that captured data is really the stored word once the access time has passed, lane masking and partial-lane writes as seen through later reads, a request withdrawn while the controller is busy, and a reset that arrives in the middle of a write pulse.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_REC,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } seq_state_e;

    // Converts a time in ns to whole clock cycles, rounding up, with a minimum of one.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (t_ns + period_ns - 1) / period_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned LANES  = 2,
    parameter int unsigned RD_CYC = 6,
    parameter int unsigned HZ_CYC = 2,
    parameter int unsigned WE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ready,
    output logic              wr_load,
    output logic              capture,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic              drive_en,
    output logic [LANES-1:0]  lane_mask
);

    localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, HZ_CYC), WE_CYC);
    localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LOAD = CNT_W'(HZ_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LOAD = CNT_W'(WE_CYC - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  mask;
        logic              sel;
        logic              oe_n;
        logic              we_n;
        logic              drive;
        logic              rvalid;
    } seq_regs_t;

    seq_regs_t q, d;
    logic      accept;
    logic      cnt_done;

    assign accept   = req_valid && (q.st == ST_IDLE);
    assign cnt_done = (q.cnt == '0);

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        capture  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.addr = req_addr;
                    d.mask = req_mask;
                    d.sel  = 1'b1;
                    if (req_write) begin
                        d.st    = ST_WR_SETUP;
                        d.drive = 1'b1;
                    end else begin
                        d.st   = ST_RD;
                        d.oe_n = 1'b0;
                        d.cnt  = RD_LOAD;
                    end
                end
            end
            ST_RD: begin
                if (cnt_done) begin
                    capture  = 1'b1;
                    d.rvalid = 1'b1;
                    d.oe_n   = 1'b1;
                    d.sel    = 1'b0;
                    d.st     = ST_RD_REC;
                    d.cnt    = HZ_LOAD;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RD_REC: begin
                if (cnt_done) d.st = ST_IDLE;
                else          d.cnt = q.cnt - 1'b1;
            end
            ST_WR_SETUP: begin
                d.we_n = 1'b0;
                d.cnt  = WE_LOAD;
                d.st   = ST_WR_PULSE;
            end
            ST_WR_PULSE: begin
                if (cnt_done) begin
                    d.we_n = 1'b1;
                    d.st   = ST_WR_HOLD;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WR_HOLD: begin
                d.sel   = 1'b0;
                d.drive = 1'b0;
                d.st    = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.cnt    <= '0;
            q.addr   <= '0;
            q.mask   <= '0;
            q.sel    <= 1'b0;
            q.oe_n   <= 1'b1;
            q.we_n   <= 1'b1;
            q.drive  <= 1'b0;
            q.rvalid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign wr_load   = accept && req_write;
    assign rd_valid  = q.rvalid;
    assign mem_addr  = q.addr;
    assign mem_sel   = q.sel;
    assign mem_oe_n  = q.oe_n;
    assign mem_we_n  = q.we_n;
    assign mem_be_n  = q.sel ? ~q.mask : {LANES{1'b1}};
    assign drive_en  = q.drive;
    assign lane_mask = q.mask;

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LANE_W-1:0] wbyte_in,
    input  logic              capture,
    input  logic              lane_en,
    input  logic              drive,
    input  logic [LANE_W-1:0] dq_i,
    output logic [LANE_W-1:0] dq_o,
    output logic              dq_oe,
    output logic [LANE_W-1:0] rbyte
);

    typedef struct packed {
        logic [LANE_W-1:0] wbyte;
        logic [LANE_W-1:0] rbyte;
    } lane_regs_t;

    lane_regs_t q, d;

    always_comb begin
        d = q;
        if (load)    d.wbyte = wbyte_in;
        if (capture) d.rbyte = lane_en ? dq_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.wbyte <= '0;
            q.rbyte <= '0;
        end else begin
            q <= d;
        end
    end

    assign dq_o  = q.wbyte;
    assign dq_oe = drive && lane_en;
    assign rbyte = q.rbyte;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_ACCESS_NS   = 55,
    parameter int unsigned T_OE_NS       = 25,
    parameter int unsigned T_HZ_NS       = 20,
    parameter int unsigned T_WE_NS       = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W/8-1:0] mem_be_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [DATA_W/8-1:0] mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = DATA_W / LANE_W;
    localparam int unsigned RD_CYC = max_u(ns_to_cycles(T_ACCESS_NS, CLK_PERIOD_NS),
                                           ns_to_cycles(T_OE_NS, CLK_PERIOD_NS));
    localparam int unsigned HZ_CYC = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
    localparam int unsigned WE_CYC = ns_to_cycles(T_WE_NS, CLK_PERIOD_NS);

    logic             wr_load;
    logic             capture;
    logic             mem_sel;
    logic             drive_en;
    logic [LANES-1:0] lane_mask;

    sram_ctrl_seq #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .RD_CYC (RD_CYC),
        .HZ_CYC (HZ_CYC),
        .WE_CYC (WE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_mask  (req_mask),
        .req_ready (req_ready),
        .wr_load   (wr_load),
        .capture   (capture),
        .rd_valid  (rsp_valid),
        .mem_addr  (mem_addr),
        .mem_sel   (mem_sel),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_be_n  (mem_be_n),
        .drive_en  (drive_en),
        .lane_mask (lane_mask)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_path #(
            .LANE_W (LANE_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (wr_load),
            .wbyte_in (req_wdata[g*LANE_W +: LANE_W]),
            .capture  (capture),
            .lane_en  (lane_mask[g]),
            .drive    (drive_en),
            .dq_i     (mem_dq_i[g*LANE_W +: LANE_W]),
            .dq_o     (mem_dq_o[g*LANE_W +: LANE_W]),
            .dq_oe    (mem_dq_oe[g]),
            .rbyte    (rsp_rdata[g*LANE_W +: LANE_W])
        );
    end

    assign mem_ce1_n = ~mem_sel;
    assign mem_ce2   = mem_sel;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_HZ_NS       = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                rsp_valid,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                mem_ce1_n,
    input logic                mem_ce2,
    input logic                mem_oe_n,
    input logic                mem_we_n,
    input logic [DATA_W/8-1:0] mem_be_n,
    input logic [DATA_W-1:0]   mem_dq_o,
    input logic [DATA_W/8-1:0] mem_dq_oe
);

    localparam int unsigned HZ_CYC = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
    localparam logic [7:0]  SAT    = 8'hFF;

    logic [7:0] since_oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             since_oe_q <= SAT;
        else if (!mem_oe_n)     since_oe_q <= '0;
        else if (since_oe_q != SAT) since_oe_q <= since_oe_q + 1'b1;
    end

    // R2
    sel_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce1_n == !mem_ce2);

    // R3
    rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce1_n));

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4
    rsp_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(mem_oe_n));

    // R6
    no_drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_dq_oe == '0));

    // R6
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_dq_oe) |-> (32'(since_oe_q) >= HZ_CYC));

    // R7
    we_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce1_n && mem_oe_n));

    // R8
    we_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |->
            ($stable(mem_addr) && $stable(mem_be_n) && $stable(mem_dq_o)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |->
            ($stable(mem_addr) && $stable(mem_be_n) && $stable(mem_dq_o) && !mem_ce1_n));

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && mem_oe_n && mem_we_n && (mem_dq_oe == '0)));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_HZ_NS       (T_HZ_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

    // Bench clock 4 ns. Per R11: ceil(55/4)=14, ceil(25/4)=7 -> RD 14; ceil(20/4)=5; ceil(40/4)=10.
    localparam int RD_CYC = 14;
    localparam int HZ_CYC = 5;
    localparam int WE_CYC = 10;

    typedef struct packed {
        logic        wr;
        logic [19:0] addr;
        logic [15:0] data;
        logic [1:0]  mask;
        logic [15:0] expv;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 20'h00005, 16'h1234, 2'b11, 16'h0000},
        '{1'b1, 20'h00009, 16'hABCD, 2'b11, 16'h0000},
        '{1'b0, 20'h00005, 16'h0000, 2'b11, 16'h1234},
        '{1'b0, 20'h00009, 16'h0000, 2'b01, 16'h00CD},
        '{1'b0, 20'h00009, 16'h0000, 2'b10, 16'hAB00},
        '{1'b1, 20'h00005, 16'hFF77, 2'b01, 16'h0000},
        '{1'b0, 20'h00005, 16'h0000, 2'b11, 16'h1277},
        '{1'b1, 20'h00009, 16'h5566, 2'b10, 16'h0000},
        '{1'b0, 20'h00009, 16'h0000, 2'b11, 16'h55CD},
        '{1'b1, 20'hFFFFF, 16'h0F0F, 2'b11, 16'h0000},
        '{1'b0, 20'hFFFFF, 16'h0000, 2'b11, 16'h0F0F},
        '{1'b0, 20'h00005, 16'h0000, 2'b00, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [19:0] mem_addr;
    logic        mem_ce1_n;
    logic        mem_ce2;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_o;
    logic [1:0]  mem_dq_oe;
    logic [15:0] mem_dq_i = '0;

    int checks = 0;
    int failures = 0;
    int oe_run = 0;
    int since_oe = 1000;
    int we_events = 0;
    logic [15:0] mem [256];

    always #2 clk = ~clk;

    sram_async_ctrl #(
        .CLK_PERIOD_NS (4)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_ce1_n (mem_ce1_n),
        .mem_ce2   (mem_ce2),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_be_n  (mem_be_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i)
    );

    // Cycle-level memory model: data appears only after RD_CYC cycles of output enable.
    always @(negedge clk) begin
        logic sel;
        sel = !mem_ce1_n && mem_ce2;
        if (sel && !mem_oe_n && mem_we_n) oe_run = oe_run + 1;
        else                              oe_run = 0;
        if (!mem_oe_n) since_oe = 0;
        else           since_oe = since_oe + 1;
        if (sel && !mem_we_n) we_events = we_events + 1;
        for (int l = 0; l < 2; l++) begin
            if (sel && !mem_we_n && !mem_be_n[l] && mem_dq_oe[l])
                mem[mem_addr[7:0]][l*8 +: 8] = mem_dq_o[l*8 +: 8];
            if (sel && !mem_oe_n && mem_we_n && !mem_be_n[l] && oe_run >= RD_CYC)
                mem_dq_i[l*8 +: 8] = mem[mem_addr[7:0]][l*8 +: 8];
            else
                mem_dq_i[l*8 +: 8] = 8'hEE;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic run_req(input vec_t v);
        int busy, oe_low, we_low, got_rv, bad, setup_ok, hold_seen, hold_ok, gap;
        logic [15:0] rd, wmask;
        busy = 0; oe_low = 0; we_low = 0; got_rv = 0; bad = 0;
        setup_ok = 0; hold_seen = 0; hold_ok = 0; gap = 0; rd = '0;
        wmask = {{8{v.mask[1]}}, {8{v.mask[0]}}};
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
        req_wdata = v.data; req_mask = v.mask;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && busy < 200) begin
            if (!mem_oe_n) begin
                oe_low++;
                if (mem_addr != v.addr || mem_be_n != ~v.mask || !mem_we_n) bad++;
            end
            if (v.wr && busy == 0) begin
                setup_ok = (!mem_ce1_n && mem_we_n && mem_addr == v.addr &&
                            mem_be_n == ~v.mask && mem_dq_oe == v.mask &&
                            (mem_dq_o & wmask) == (v.data & wmask)) ? 1 : 0;
                gap = since_oe;
            end
            if (!mem_we_n) begin
                we_low++;
                if (mem_addr != v.addr || mem_be_n != ~v.mask || mem_dq_oe != v.mask ||
                    (mem_dq_o & wmask) != (v.data & wmask) || !mem_oe_n) bad++;
            end else if (we_low > 0 && hold_seen == 0) begin
                hold_seen = 1;
                hold_ok = (!mem_ce1_n && mem_addr == v.addr && mem_be_n == ~v.mask &&
                           mem_dq_oe == v.mask && (mem_dq_o & wmask) == (v.data & wmask)) ? 1 : 0;
            end
            if (rsp_valid) begin
                got_rv++;
                rd = rsp_rdata;
            end
            busy++;
            @(negedge clk);
        end
        if (v.wr) begin
            chk(we_low == WE_CYC, "R7", "write pulse cycles", 32'(we_low), 32'(WE_CYC));
            chk(setup_ok == 1, "R7", "setup cycle", 32'(setup_ok), 1);
            chk(hold_ok == 1, "R8", "hold cycle", 32'(hold_ok), 1);
            chk(bad == 0, "R9", "lane drive and stability in pulse", 32'(bad), 0);
            chk(busy == WE_CYC + 2, "R10", "write busy cycles", 32'(busy), 32'(WE_CYC + 2));
            chk(got_rv == 0, "R4", "no response for write", 32'(got_rv), 0);
            chk(gap >= HZ_CYC, "R6", "turnaround before drive", 32'(gap), 32'(HZ_CYC));
        end else begin
            chk(oe_low == RD_CYC, "R3", "output enable cycles", 32'(oe_low), 32'(RD_CYC));
            chk(bad == 0, "R3", "address and lane enables in read", 32'(bad), 0);
            chk(got_rv == 1, "R4", "single response pulse", 32'(got_rv), 1);
            chk(rd == v.expv, "R5", "read data", 32'(rd), 32'(v.expv));
            chk(busy == RD_CYC + HZ_CYC, "R10", "read busy cycles", 32'(busy),
                32'(RD_CYC + HZ_CYC));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ce1_n == 1'b1 && mem_ce2 == 1'b0, "R1", "selects idle in reset",
            {30'b0, mem_ce1_n, mem_ce2}, 32'h2);
        chk(mem_oe_n && mem_we_n, "R1", "strobes idle in reset",
            {30'b0, mem_oe_n, mem_we_n}, 32'h3);
        chk(mem_be_n == 2'b11 && mem_dq_oe == 2'b00, "R1", "lanes idle in reset",
            {28'b0, mem_be_n, mem_dq_oe}, 32'hC);
        chk(req_ready && !rsp_valid, "R1", "handshake in reset",
            {30'b0, req_ready, rsp_valid}, 32'h2);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle controller keeps the chip deselected
        chk(mem_ce1_n == 1'b1 && mem_ce2 == 1'b0, "R2", "deselected when idle",
            {30'b0, mem_ce1_n, mem_ce2}, 32'h2);

        // R11 counts used throughout the table walk.
        for (int i = 0; i < NVEC; i++) run_req(VECS[i]);

        // R10: request offered while busy and withdrawn is not performed.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00009; req_mask = 2'b11;
        @(negedge clk);
        req_write = 1'b1; req_addr = 20'h00005; req_wdata = 16'h0000;
        we_events = 0;
        repeat (5) @(negedge clk);
        chk(req_ready == 1'b0, "R10", "busy during read", 32'(req_ready), 0);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        chk(we_events == 0, "R10", "withdrawn write not issued", 32'(we_events), 0);
        run_req('{1'b0, 20'h00005, 16'h0000, 2'b11, 16'h1277});

        // R1: reset in the middle of a write pulse
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00003;
        req_wdata = 16'h9999; req_mask = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(mem_we_n == 1'b0, "R7", "pulse active before reset", 32'(mem_we_n), 0);
        rst_n = 1'b0;
        #1;
        chk(mem_we_n && mem_ce1_n && !mem_ce2 && mem_dq_oe == 2'b00, "R1",
            "idle right after mid-write reset",
            {28'b0, mem_we_n, mem_ce1_n, mem_ce2, |mem_dq_oe}, 32'hC);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset release", 32'(req_ready), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule